// File: doc/BRIEF.md
# Huffman Decompress-on-Fetch Unit

This unit sits between a level-one store that holds compressed code and the processor's fetch stage. Each 32-bit instruction is stored as four 8-bit symbols, each written with a fixed canonical Huffman code of at most 16 bits. The unit pulls compressed bytes one at a time, decodes the bit stream one bit per cycle, and packs the four symbols into a full instruction word. The processor receives that word over a valid/ready output.

Instructions are grouped into lines of `LINE_WORDS` words, and every line starts on a byte boundary in the compressed store. A line address table outside the unit gives the byte address of each line. The unit looks this address up whenever the fetch is a taken branch or lands on the first word of a line. It then restarts decoding from that byte and drops any bits still held from the previous byte. Because of this, any branch target that begins a line can be entered directly. A fetch that a loop buffer serves is flagged as such; the unit accepts it at once and leaves its decoding position untouched.

Fetch requests use valid/ready. `req_ready` is high only when the unit is idle. The output word uses valid/ready as well. Once `out_valid` rises, it stays high and `out_instr` stays constant until the cycle in which `out_ready` is high. No new request is accepted before that cycle.

Top module: `huff_fetch_decomp`

## Requirements
- R1: After reset, `out_valid` is 0, `req_ready` is 1 and the decode position is byte 0 with no buffered bits.
- R2: Symbol codes are canonical. A length L has 2^(L/2-1) codes for even L from 2 to 14, length 16 has 129 codes, and other lengths have none. Symbol values are assigned in increasing order, shorter lengths first, with consecutive code values within each length. Bits are read most significant bit first within each byte, and bytes are read in increasing address order.
- R3: The first symbol decoded for an instruction lands in `out_instr[31:24]`, and the fourth lands in `out_instr[7:0]`.
- R4: An accepted non-loop request restarts decoding when `req_jump` is 1 or when `req_addr` is a multiple of `LINE_WORDS` (4). The restart reads from byte `lat_byte`, which is looked up at `lat_line = req_addr / LINE_WORDS` in the cycle of acceptance, and discards all buffered bits.
- R5: An accepted non-loop request with `req_jump` = 0 whose address is not at a line start continues decoding at the bit that follows the previous instruction.
- R6: A request with `req_loop` = 1 is accepted while the unit is idle. It produces no output word, leaves `req_ready` high, and does not move the decode position.
- R7: `out_valid` rises only after all four symbols are decoded. While `out_valid` is 1 and `out_ready` is 0, `out_instr` holds its value and `req_ready` is 0. `out_valid` falls after the handshake cycle.
- R8: `mem_data` must carry the byte at `mem_addr`, and `lat_byte` the entry at `lat_line`, in the same cycle (combinational reads).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | WADDR_W | Uncompressed word address of the fetch |
| req_jump | input | 1 | Fetch follows a taken branch |
| req_loop | input | 1 | Fetch is served by the loop buffer |
| lat_line | output | WADDR_W-log2(LINE_WORDS) | Line index into the line address table |
| lat_byte | input | BADDR_W | Compressed byte address of that line |
| mem_addr | output | BADDR_W | Compressed byte being read |
| mem_data | input | 8 | Byte at `mem_addr` |
| out_valid | output | 1 | Decoded instruction available |
| out_ready | input | 1 | Processor takes the instruction |
| out_instr | output | 32 | Decoded instruction word |

## Verification
The bench uses the default parameters: 10-bit word addresses, 12-bit byte addresses and four-word lines. A 64-instruction program therefore fills 16 lines of the table and a few hundred bytes of compressed store. This puts line-start restarts, branch restarts that drop a part-used byte, and sequential runs across line boundaries all in reach. Directed words of all-zero and all-ones bytes cover the shortest and longest codes. Random stalls and loop-buffer fetches mixed into the stream cover back-pressure and a decode position that must stay where it is.

// File: rtl/hdf_pkg.sv
package hdf_pkg;
  localparam int SYM_W    = 8;
  localparam int MAX_LEN  = 16;
  localparam int SYMS     = 4;
  localparam int INSTR_W  = SYM_W * SYMS;

  typedef logic [16:0] ctab_t [0:MAX_LEN];

  typedef enum logic [1:0] {ST_IDLE, ST_DEC, ST_HOLD} hdf_state_e;

  // number of codewords of a given length
  function automatic logic [16:0] len_count(input int len);
    if (len >= 2 && len <= 14 && (len % 2) == 0) return 17'(1 << (len / 2 - 1));
    if (len == MAX_LEN) return 17'd129;
    return 17'd0;
  endfunction

  function automatic ctab_t calc_count();
    ctab_t t;
    for (int l = 0; l <= MAX_LEN; l++) t[l] = len_count(l);
    return t;
  endfunction

  // smallest code value of each length
  function automatic ctab_t calc_first();
    ctab_t t;
    t[0] = '0;
    t[1] = '0;
    for (int l = 2; l <= MAX_LEN; l++) t[l] = (t[l-1] + len_count(l-1)) << 1;
    return t;
  endfunction

  // symbol value carried by the smallest code of each length
  function automatic ctab_t calc_base();
    ctab_t t;
    t[0] = '0;
    t[1] = '0;
    for (int l = 2; l <= MAX_LEN; l++) t[l] = t[l-1] + len_count(l-1);
    return t;
  endfunction

  localparam ctab_t CNT_T   = calc_count();
  localparam ctab_t FIRST_T = calc_first();
  localparam ctab_t BASE_T  = calc_base();
endpackage

// File: rtl/hdf_bitsrc.sv
module hdf_bitsrc #(
  parameter int BADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [BADDR_W-1:0] restart_byte,
  input  logic               active,
  output logic [BADDR_W-1:0] mem_addr,
  input  logic [7:0]         mem_data,
  output logic               bit_ok,
  output logic               bit_val
);
  logic [BADDR_W-1:0] byte_ptr;
  logic [7:0]         sreg;
  logic [3:0]         nbits;

  assign mem_addr = byte_ptr;
  assign bit_ok   = active && (nbits != 4'd0);
  assign bit_val  = sreg[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_ptr <= '0;
      sreg     <= '0;
      nbits    <= '0;
    end else if (restart) begin
      byte_ptr <= restart_byte;
      nbits    <= '0;
    end else if (active && nbits == 4'd0) begin
      sreg     <= mem_data;
      nbits    <= 4'd8;
      byte_ptr <= byte_ptr + 1'b1;
    end else if (bit_ok) begin
      sreg     <= {sreg[6:0], 1'b0};
      nbits    <= nbits - 1'b1;
    end
  end
endmodule

// File: rtl/hdf_symdec.sv
module hdf_symdec
  import hdf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bit_ok,
  input  logic             bit_val,
  output logic             sym_ok,
  output logic [SYM_W-1:0] sym
);
  logic [15:0] code_q;
  logic [4:0]  len_q;
  logic [16:0] ncode;
  logic [4:0]  nlen;
  logic        hit;

  always_comb begin
    ncode  = {code_q, bit_val};
    nlen   = len_q + 5'd1;
    hit    = (ncode >= FIRST_T[nlen]) && (ncode < FIRST_T[nlen] + CNT_T[nlen]);
    sym    = hit ? SYM_W'(BASE_T[nlen] + (ncode - FIRST_T[nlen])) : '0;
    sym_ok = bit_ok && (hit || nlen == 5'(MAX_LEN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      code_q <= '0;
      len_q  <= '0;
    end else if (bit_ok) begin
      if (sym_ok) begin
        code_q <= '0;
        len_q  <= '0;
      end else begin
        code_q <= ncode[15:0];
        len_q  <= nlen;
      end
    end
  end
endmodule

// File: rtl/huff_fetch_decomp.sv
module huff_fetch_decomp
  import hdf_pkg::*;
#(
  parameter int WADDR_W    = 10,
  parameter int BADDR_W    = 12,
  parameter int LINE_WORDS = 4,
  localparam int LINE_SH   = $clog2(LINE_WORDS),
  localparam int LIDX_W    = WADDR_W - LINE_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic               req_jump,
  input  logic               req_loop,
  output logic [LIDX_W-1:0]  lat_line,
  input  logic [BADDR_W-1:0] lat_byte,
  output logic [BADDR_W-1:0] mem_addr,
  input  logic [7:0]         mem_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_instr
);
  localparam int CNT_W = $clog2(SYMS);
  localparam logic [WADDR_W-1:0] LMASK = WADDR_W'(LINE_WORDS - 1);

  hdf_state_e         state;
  logic [CNT_W-1:0]   scnt;
  logic [INSTR_W-1:0] word_q;
  logic               accept, go, restart, line_start;
  logic               bit_ok, bit_val, sym_ok;
  logic [SYM_W-1:0]   sym;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign go         = accept && !req_loop;
  assign line_start = ((req_addr & LMASK) == '0);
  assign restart    = go && (req_jump || line_start);
  assign lat_line   = LIDX_W'(req_addr >> LINE_SH);
  assign out_valid  = (state == ST_HOLD);
  assign out_instr  = word_q;

  hdf_bitsrc #(.BADDR_W(BADDR_W)) i_bitsrc (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .restart_byte (lat_byte),
    .active       (state == ST_DEC),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data),
    .bit_ok       (bit_ok),
    .bit_val      (bit_val)
  );

  hdf_symdec i_symdec (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (go),
    .bit_ok  (bit_ok),
    .bit_val (bit_val),
    .sym_ok  (sym_ok),
    .sym     (sym)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      scnt   <= '0;
      word_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_DEC;
          scnt  <= '0;
        end
        ST_DEC: if (sym_ok) begin
          word_q <= {word_q[INSTR_W-SYM_W-1:0], sym};
          scnt   <= scnt + 1'b1;
          if (scnt == CNT_W'(SYMS - 1)) state <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdf_chk.sv
module hdf_chk #(
  parameter int BADDR_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_jump,
  input logic               req_loop,
  input logic [BADDR_W-1:0] lat_byte,
  input logic [BADDR_W-1:0] mem_addr,
  input logic               out_valid,
  input logic               out_ready,
  input logic [31:0]        out_instr
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_instr));
  // R7
  no_accept_while_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
  // R6
  loop_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_loop |=> !out_valid && req_ready);
  // R6
  loop_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_loop |=> $stable(mem_addr));
  // R4
  jump_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_loop && req_jump |=> mem_addr == $past(lat_byte));
endmodule

bind huff_fetch_decomp hdf_chk #(.BADDR_W(BADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_jump  (req_jump),
  .req_loop  (req_loop),
  .lat_byte  (lat_byte),
  .mem_addr  (mem_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_instr (out_instr)
);

// File: tb/test_huff_fetch_decomp.sv
module test_huff_fetch_decomp;
  localparam int NW = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_jump = 0, req_loop = 0, out_ready = 0;
  logic [9:0]  req_addr = '0;
  logic        req_ready, out_valid;
  logic [7:0]  lat_line;
  logic [11:0] lat_byte, mem_addr;
  logic [7:0]  mem_data;
  logic [31:0] out_instr;

  logic [7:0]  cmem [0:4095];
  logic [11:0] lat  [0:255];
  logic [31:0] prog [0:NW-1];
  int checks = 0, errors = 0;
  int cnt_l [0:16], first_l [0:16], base_l [0:16];
  int bitpos = 0;

  always #10 clk = ~clk;

  // R8: combinational reads of table and store
  assign mem_data = cmem[mem_addr];
  assign lat_byte = lat[lat_line];

  huff_fetch_decomp i_huff_fetch_decomp (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int tb_cnt(input int l);
    if (l == 16) return 129;
    if (l >= 2 && l <= 14 && l % 2 == 0) return 1 << (l / 2 - 1);
    return 0;
  endfunction

  task automatic put_bit(input bit b);
    cmem[bitpos / 8][7 - bitpos % 8] = b;
    bitpos++;
  endtask

  task automatic put_sym(input int s);
    for (int l = 1; l <= 16; l++)
      if (s >= base_l[l] && s < base_l[l] + cnt_l[l]) begin
        int c = first_l[l] + s - base_l[l];
        for (int b = l - 1; b >= 0; b--) put_bit(c[b]);
      end
  endtask

  // one fetch; checks the word when not a loop hit
  task automatic fetch(input int a, input bit jmp, input bit lp, input string req);
    logic [31:0] held;
    int stall;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = 10'(a); req_jump = jmp; req_loop = lp;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_jump = 0; req_loop = 0;
    if (lp) begin
      // R6: no word, still ready
      chk(!out_valid && req_ready, "R6", {30'd0, out_valid, req_ready}, 32'd1);
      return;
    end
    while (!out_valid) @(negedge clk);
    held = out_instr;
    stall = $urandom_range(0, 3);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      // R7: held under back-pressure
      chk(out_valid && !req_ready && out_instr == held, "R7", out_instr, held);
    end
    chk(out_instr == prog[a], req, out_instr, prog[a]);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 0;
    // R7: valid drops after handshake
    chk(!out_valid, "R7", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) cmem[i] = 8'h00;
    for (int i = 0; i < 256; i++) lat[i] = '0;
    first_l[0] = 0; first_l[1] = 0; base_l[0] = 0; base_l[1] = 0;
    for (int l = 0; l <= 16; l++) cnt_l[l] = tb_cnt(l);
    for (int l = 2; l <= 16; l++) begin
      first_l[l] = (first_l[l-1] + cnt_l[l-1]) * 2;
      base_l[l]  = base_l[l-1] + cnt_l[l-1];
    end
    for (int i = 0; i < NW; i++) prog[i] = $urandom;
    prog[0] = 32'h0000_0000;   // shortest codes
    prog[1] = 32'hFFFF_FFFF;   // longest codes
    prog[2] = 32'h0102_0304;
    prog[5] = 32'h80FF_0001;
    for (int i = 0; i < NW; i++) begin
      if (i % 4 == 0) begin
        while (bitpos % 8 != 0) put_bit(1'b0);
        lat[i / 4] = 12'(bitpos / 8);
      end
      put_sym(int'(prog[i][31:24])); put_sym(int'(prog[i][23:16]));
      put_sym(int'(prog[i][15:8]));  put_sym(int'(prog[i][7:0]));
    end

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!out_valid && req_ready && mem_addr == 12'd0, "R1",
        {19'd0, out_valid, req_ready, mem_addr}, 32'h0000_1000);

    // sequential pass with loop-buffer hits mixed in: R2, R3, R5, R6
    for (int i = 0; i < NW; i++) begin
      if ($urandom_range(0, 4) == 0) fetch($urandom_range(0, NW - 1), 1'b0, 1'b1, "R6");
      fetch(i, i == 0, 1'b0, (i % 4 == 0) ? "R4" : (i < 3 ? "R2 R3" : "R5"));
    end

    // branch restarts to line starts, then short sequential runs: R4, R5
    for (int j = 0; j < 40; j++) begin
      int t = 4 * $urandom_range(0, NW / 4 - 1);
      int n = $urandom_range(0, 5);
      fetch(t, 1'b1, 1'b0, "R4");
      for (int k = 1; k <= n && t + k < NW; k++) begin
        if ($urandom_range(0, 3) == 0) fetch(0, 1'b0, 1'b1, "R6");
        fetch(t + k, 1'b0, 1'b0, ((t + k) % 4 == 0) ? "R4" : "R5");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule